// File: doc/BRIEF.md
# Dual-Channel Bus-Master Disk DMA Register Front End

This block is the register file that software uses to steer a two-channel bus-master disk DMA controller. It sits behind a 16-byte I/O window and gives each channel an 8-byte slice. The lower half of a slice holds a command byte and a status byte. The upper half holds a 32-bit pointer to the descriptor table. Accesses arrive as single-cycle requests that carry an address, a size code and 32-bit lane-aligned write data. Read data comes back combinationally on the same lanes.

Each channel runs a two-state controller. In `CH_IDLE` the channel is stopped. In `CH_ACTIVE` the DMA engine owns the transfer. The START transition (`CH_IDLE` to `CH_ACTIVE`) fires when software writes the run bit from 0 to 1. The STOP transition (`CH_ACTIVE` to `CH_IDLE`) fires when software writes the run bit from 1 to 0. The FINISH transition (`CH_ACTIVE` to `CH_IDLE`) fires when the engine raises its done input. Status bit 0 reads 1 exactly in `CH_ACTIVE`.

START and STOP also produce one-cycle strobes toward the engine. The engine reports error and interrupt events through set inputs. Those events are held in sticky, write-one-to-clear status bits, and the interrupt bit drives a per-channel interrupt line.

Top module: `ide_busmaster_regs`

## Requirements
- R1: Channel n owns offsets 8n to 8n+7, selected by address bits [AW-1:3]. Within a slice, offset 0 is command, offset 2 is status and offsets 4 to 7 are the descriptor pointer. A byte read at offset 1 or 3 returns 0xFF on that lane. Data sits on byte lane = offset mod 4, and lanes that are not read return 0.
- R2: Size code 0 is a byte access on lane addr[1:0]. Code 1 is a halfword on lanes 0-1 (addr[1]=0) or lanes 2-3 (addr[1]=1). Codes 2 and 3 are words on all four lanes. Any non-byte read of offsets 0 to 3 returns 0xFF on every enabled lane. Any non-byte write there changes nothing and produces no strobe.
- R3: Command bit 0 (run) and bit 3 (direction) are stored, and the other command bits read 0. `dma_dir_o` equals bit 3. Byte writes to offsets 1 and 3 have no effect.
- R4: A byte write W to status sets the new status to (W & 0x60) | (old & 0x01) | (old & ~W & 0x06), provided no engine set input fires in that cycle.
- R5: A run-bit write from 0 to 1 sets status bit 0 and pulses `dma_start_o` for exactly the cycle after the write. A run-bit write from 1 to 0 clears status bit 0 and pulses `dma_stop_o` in the same way. Rewriting the current run value produces no strobe.
- R6: `eng_done` in `CH_ACTIVE` clears status bit 0 and leaves the command byte unchanged.
- R7: `eng_err_set` sets status bit 1 and `eng_irq_set` sets status bit 2. A set in the same cycle as a software clear of that bit leaves the bit at 1.
- R8: `irq_o[n]` equals status bit 2 of channel n.
- R9: Pointer writes update only the enabled byte lanes, and pointer bits [1:0] always read 0. `prd_base_o` carries each channel's pointer.
- R10: After reset, the command, status and pointer of every channel read 0, and the strobes are low.
- R11: An access to one channel never changes another channel's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset in the window |
| bus_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| bus_wdata | input | 32 | Lane-aligned write data |
| bus_rdata | output | 32 | Lane-aligned read data |
| eng_err_set | input | NCH | Engine error event per channel |
| eng_irq_set | input | NCH | Engine interrupt event per channel |
| eng_done | input | NCH | Engine finished, drop active |
| dma_start_o | output | NCH | One-cycle start strobe |
| dma_stop_o | output | NCH | One-cycle stop strobe |
| dma_dir_o | output | NCH | Transfer direction bit |
| irq_o | output | NCH | Interrupt line per channel |
| prd_base_o | output | 32*NCH | Descriptor pointer per channel |

## Verification
The bench drives every status byte value against sixteen prior states of each channel. A design that swapped the write-one-to-clear and read/write masks, or that let software touch the active bit, would mismatch on thousands of these cases. Every offset is read with all three sizes, which catches a wide read that returns stored data instead of ones, or ones on the wrong lanes. Targeted cases repeat a run write without an edge, end a transfer through the done input, and collide an engine set with a software clear. A design that strobed on level, dropped the command on completion or let the clear win would fail these cases. Halfword and byte pointer writes that leave other lanes intact, and a low two-bit field that never sticks, cover pointer lane handling.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef enum logic {
        CH_IDLE   = 1'b0,
        CH_ACTIVE = 1'b1
    } ch_state_e;

    localparam int CMD_RUN   = 0;
    localparam int CMD_DIR   = 3;
    localparam int ST_ACTIVE = 0;
    localparam int ST_ERR    = 1;
    localparam int ST_IRQ    = 2;

    localparam logic [7:0] CMD_KEEP_MASK = 8'h09;
    localparam int SLICE_BITS = 3;
endpackage

// File: rtl/ide_bm_decode.sv
module ide_bm_decode
    import ide_bm_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 4
) (
    input  logic           req_valid,
    input  logic           req_write,
    input  logic [AW-1:0]  req_addr,
    input  logic [1:0]     req_size,
    output logic [3:0]     lane_en,
    output logic           byte_acc,
    output logic           ptr_half,
    output logic [NCH-1:0] cmd_we,
    output logic [NCH-1:0] stat_we,
    output logic [NCH-1:0] ptr_we
);
    localparam int CHW = AW - SLICE_BITS;

    logic [CHW-1:0] ch_idx;
    assign ch_idx   = req_addr[AW-1:SLICE_BITS];
    assign ptr_half = req_addr[2];
    assign byte_acc = (acc_size_e'(req_size) == SZ_BYTE);

    always_comb begin
        unique case (acc_size_e'(req_size))
            SZ_BYTE: lane_en = 4'b0001 << req_addr[1:0];
            SZ_HALF: lane_en = req_addr[1] ? 4'b1100 : 4'b0011;
            default: lane_en = 4'b1111;
        endcase
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit        = req_valid && req_write && (ch_idx == CHW'(g));
        assign cmd_we[g]  = hit && !ptr_half && byte_acc && (req_addr[1:0] == 2'd0);
        assign stat_we[g] = hit && !ptr_half && byte_acc && (req_addr[1:0] == 2'd2);
        assign ptr_we[g]  = hit && ptr_half;
    end

    always_comb begin
        // R1
        single_target_chk: assert ($onehot0({cmd_we, stat_we, ptr_we}));
    end
endmodule

// File: rtl/ide_bm_channel.sv
module ide_bm_channel
    import ide_bm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic        stat_we,
    input  logic        ptr_we,
    input  logic [3:0]  lane_en,
    input  logic [31:0] wdata,
    input  logic        eng_err_set,
    input  logic        eng_irq_set,
    input  logic        eng_done,
    output logic [7:0]  cmd_q,
    output logic [7:0]  status,
    output logic [31:0] ptr_q,
    output logic        start_p,
    output logic        stop_p,
    output logic        dir,
    output logic        irq
);
    ch_state_e   state_q, state_d;
    logic [7:0]  wcmd, wst;
    logic        run_rise, run_fall;
    logic        err_q, irq_q;
    logic [1:0]  rw_q;

    assign wcmd     = wdata[7:0];
    assign wst      = wdata[23:16];
    assign run_rise = cmd_we && wcmd[CMD_RUN] && !cmd_q[CMD_RUN];
    assign run_fall = cmd_we && !wcmd[CMD_RUN] && cmd_q[CMD_RUN];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:   if (run_rise) state_d = CH_ACTIVE;
            CH_ACTIVE: if (run_fall || eng_done) state_d = CH_IDLE;
            default:   state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_p <= 1'b0;
            stop_p  <= 1'b0;
        end else begin
            start_p <= run_rise;
            stop_p  <= run_fall;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            err_q <= 1'b0;
            irq_q <= 1'b0;
            rw_q  <= '0;
        end else begin
            if (cmd_we)  cmd_q <= wcmd & CMD_KEEP_MASK;
            if (stat_we) rw_q  <= wst[6:5];
            err_q <= eng_err_set | (err_q & ~(stat_we & wst[ST_ERR]));
            irq_q <= eng_irq_set | (irq_q & ~(stat_we & wst[ST_IRQ]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            for (int b = 0; b < 4; b++) begin
                if (ptr_we && lane_en[b]) ptr_q[8*b +: 8] <= wdata[8*b +: 8];
            end
            ptr_q[1:0] <= 2'b00;
        end
    end

    assign status = {1'b0, rw_q, 2'b00, irq_q, err_q, (state_q == CH_ACTIVE)};
    assign dir    = cmd_q[CMD_DIR];
    assign irq    = irq_q;

    // R5
    start_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |-> status[ST_ACTIVE]);
    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_p && stop_p));
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_err_set |=> status[ST_ERR]);
    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_irq_set |=> irq);
    // R4
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_err_set && !(stat_we && wst[ST_ERR])) |=> (status[ST_ERR] == $past(status[ST_ERR])));
    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !cmd_we) |=> !status[ST_ACTIVE]);
endmodule

// File: rtl/ide_busmaster_regs.sv
module ide_busmaster_regs
    import ide_bm_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = $clog2(NCH) + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [AW-1:0]     bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NCH-1:0]    eng_err_set,
    input  logic [NCH-1:0]    eng_irq_set,
    input  logic [NCH-1:0]    eng_done,
    output logic [NCH-1:0]    dma_start_o,
    output logic [NCH-1:0]    dma_stop_o,
    output logic [NCH-1:0]    dma_dir_o,
    output logic [NCH-1:0]    irq_o,
    output logic [32*NCH-1:0] prd_base_o
);
    localparam int CHW = AW - SLICE_BITS;

    logic [3:0]     lane_en;
    logic           byte_acc, ptr_half;
    logic [NCH-1:0] cmd_we, stat_we, ptr_we;
    logic [7:0]     ch_cmd  [NCH];
    logic [7:0]     ch_stat [NCH];
    logic [31:0]    ch_ptr  [NCH];
    logic [CHW-1:0] rd_ch;

    ide_bm_decode #(.NCH(NCH), .AW(AW)) u_decode (
        .req_valid (bus_valid),
        .req_write (bus_write),
        .req_addr  (bus_addr),
        .req_size  (bus_size),
        .lane_en   (lane_en),
        .byte_acc  (byte_acc),
        .ptr_half  (ptr_half),
        .cmd_we    (cmd_we),
        .stat_we   (stat_we),
        .ptr_we    (ptr_we)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        ide_bm_channel u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .cmd_we      (cmd_we[g]),
            .stat_we     (stat_we[g]),
            .ptr_we      (ptr_we[g]),
            .lane_en     (lane_en),
            .wdata       (bus_wdata),
            .eng_err_set (eng_err_set[g]),
            .eng_irq_set (eng_irq_set[g]),
            .eng_done    (eng_done[g]),
            .cmd_q       (ch_cmd[g]),
            .status      (ch_stat[g]),
            .ptr_q       (ch_ptr[g]),
            .start_p     (dma_start_o[g]),
            .stop_p      (dma_stop_o[g]),
            .dir         (dma_dir_o[g]),
            .irq         (irq_o[g])
        );
        assign prd_base_o[32*g +: 32] = ch_ptr[g];
    end

    assign rd_ch = bus_addr[AW-1:SLICE_BITS];

    always_comb begin
        bus_rdata = '0;
        if (int'(rd_ch) < NCH) begin
            if (!ptr_half) begin
                if (!byte_acc) begin
                    for (int b = 0; b < 4; b++)
                        if (lane_en[b]) bus_rdata[8*b +: 8] = 8'hFF;
                end else begin
                    unique case (bus_addr[1:0])
                        2'd0: bus_rdata[7:0]   = ch_cmd[rd_ch];
                        2'd1: bus_rdata[15:8]  = 8'hFF;
                        2'd2: bus_rdata[23:16] = ch_stat[rd_ch];
                        default: bus_rdata[31:24] = 8'hFF;
                    endcase
                end
            end else begin
                for (int b = 0; b < 4; b++)
                    if (lane_en[b]) bus_rdata[8*b +: 8] = ch_ptr[rd_ch][8*b +: 8];
            end
        end
    end
endmodule

// File: tb/ide_busmaster_regs_bench.sv
module ide_busmaster_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int AW  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0, bus_write = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [1:0]        bus_size = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    eng_err_set = '0, eng_irq_set = '0, eng_done = '0;
    logic [NCH-1:0]    dma_start_o, dma_stop_o, dma_dir_o, irq_o;
    logic [32*NCH-1:0] prd_base_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0]  m_cmd [NCH];
    logic [7:0]  m_st  [NCH];
    logic [31:0] m_ptr [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    ide_busmaster_regs #(.NCH(NCH)) u_ide_busmaster_regs (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int sz, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = AW'(a); bus_size = 2'(sz); bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input int a, input int sz, output logic [31:0] q);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = AW'(a); bus_size = 2'(sz);
        #1 q = bus_rdata;
        bus_valid = 0;
    endtask

    task automatic eng(input int ch, input bit e, input bit i, input bit d);
        @(negedge clk);
        eng_err_set[ch] = e; eng_irq_set[ch] = i; eng_done[ch] = d;
        @(negedge clk);
        eng_err_set = '0; eng_irq_set = '0; eng_done = '0;
    endtask

    function automatic logic [31:0] exp_rd(input int a, input int sz);
        int ch = a >> 3;
        int off = a & 7;
        logic [3:0] ln;
        logic [31:0] r = '0;
        if (sz == 0) ln = 4'b0001 << (off & 3);
        else if (sz == 1) ln = (off & 2) ? 4'b1100 : 4'b0011;
        else ln = 4'b1111;
        for (int b = 0; b < 4; b++) begin
            if (ln[b]) begin
                if (off >= 4) r[8*b +: 8] = m_ptr[ch][8*b +: 8];
                else if (sz != 0) r[8*b +: 8] = 8'hFF;
                else if ((off & 3) == 0) r[8*b +: 8] = m_cmd[ch];
                else if ((off & 3) == 2) r[8*b +: 8] = m_st[ch];
                else r[8*b +: 8] = 8'hFF;
            end
        end
        return r;
    endfunction

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] q;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int c = 0; c < NCH; c++) begin
            m_cmd[c] = 0; m_st[c] = 0; m_ptr[c] = 0;
        end
        // R10 reset state
        for (int a = 0; a < 16; a++) begin
            rd(a, 0, q); chk("R10 reset byte", q, exp_rd(a, 0));
        end
        chk("R10 reset outputs", {dma_start_o, dma_stop_o, dma_dir_o, irq_o}, '0);
        chk("R10 reset ptr out", prd_base_o, '0);

        // R3 / R5 start with direction
        wr(0, 0, 32'hFF);
        chk("R5 start strobe", dma_start_o, 2'b01);
        chk("R3 dir out", dma_dir_o, 2'b01);
        m_cmd[0] = 8'h09; m_st[0] = 8'h01;
        @(negedge clk);
        chk("R5 strobe one cycle", dma_start_o, 2'b00);
        rd(0, 0, q); chk("R3 cmd readback", q, exp_rd(0, 0));
        rd(2, 0, q); chk("R5 active set", q, exp_rd(2, 0));
        wr(0, 0, 32'h09);
        chk("R5 no strobe on repeat", {dma_start_o, dma_stop_o}, '0);
        // R3 writes at offsets 1 and 3
        wr(1, 0, 32'hFFFF_FFFF);
        wr(3, 0, 32'hFFFF_FFFF);
        rd(0, 0, q); chk("R3 off1/3 no effect cmd", q, exp_rd(0, 0));
        rd(2, 0, q); chk("R3 off1/3 no effect st", q, exp_rd(2, 0));
        // R2 wide writes ignored
        wr(0, 2, 32'h0000_0000);
        chk("R2 wide write no strobe", dma_stop_o, 2'b00);
        wr(2, 1, 32'h0066_0000);
        rd(0, 0, q); chk("R2 wide write cmd kept", q, exp_rd(0, 0));
        rd(2, 0, q); chk("R2 wide write st kept", q, exp_rd(2, 0));
        // R5 stop
        wr(0, 0, 32'h08);
        chk("R5 stop strobe", dma_stop_o, 2'b01);
        m_cmd[0] = 8'h08; m_st[0] = 8'h00;
        rd(2, 0, q); chk("R5 active cleared", q, exp_rd(2, 0));
        // R6 finish through engine
        wr(0, 0, 32'h01);
        m_cmd[0] = 8'h01;
        eng(0, 0, 0, 1);
        chk("R6 no stop strobe on done", dma_stop_o, 2'b00);
        rd(2, 0, q); chk("R6 active dropped", q, 32'h0);
        rd(0, 0, q); chk("R6 cmd kept", q, exp_rd(0, 0));
        wr(0, 0, 32'h00);
        chk("R5 stop after done", dma_stop_o, 2'b01);
        m_cmd[0] = 8'h00;

        // R9 pointer lanes, R11 isolation
        wr(4, 2, 32'hDEAD_BEEF); m_ptr[0] = 32'hDEAD_BEEC;
        rd(4, 2, q); chk("R9 word ptr", q, exp_rd(4, 2));
        wr(6, 1, 32'h1234_0000); m_ptr[0] = 32'h1234_BEEC;
        rd(4, 2, q); chk("R9 half ptr", q, exp_rd(4, 2));
        wr(5, 0, 32'h0000_5500); m_ptr[0] = 32'h1234_55EC;
        wr(4, 0, 32'h0000_00FF); m_ptr[0] = 32'h1234_55FC;
        rd(4, 2, q); chk("R9 byte ptr", q, exp_rd(4, 2));
        chk("R9 ptr out", prd_base_o, {32'h0, 32'h1234_55FC});
        rd(12, 2, q); chk("R11 other channel ptr", q, 32'h0);

        // R7 set beats clear
        eng(0, 1, 1, 0);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 2; bus_size = 0; bus_wdata = 32'h0006_0000;
        eng_err_set[0] = 1;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; eng_err_set = '0;
        m_st[0] = 8'h02;
        rd(2, 0, q); chk("R7 set wins over clear", q, exp_rd(2, 0));
        chk("R8 irq low after clear", irq_o, 2'b00);
        wr(2, 0, 32'h0002_0000); m_st[0] = 8'h00;

        // R1 map sweep
        wr(8, 0, 32'h08);  m_cmd[1] = 8'h08;
        wr(10, 0, 32'h0060_0000); m_st[1] = 8'h60;
        wr(12, 2, 32'hA5C3_0F17); m_ptr[1] = 32'hA5C3_0F14;
        chk("R11 dir ch1 only", dma_dir_o, 2'b10);
        for (int a = 0; a < 16; a++)
            for (int sz = 0; sz < 3; sz++) begin
                rd(a, sz, q); chk($sformatf("R1 R2 map a=%0d sz=%0d", a, sz), q, exp_rd(a, sz));
            end

        // R4 status sweep
        for (int c = 0; c < NCH; c++)
            for (int o = 0; o < 16; o++)
                for (int w = 0; w < 256; w++) begin
                    logic [7:0] old, ex;
                    wr(8*c + 2, 0, {8'h0, (8'h06 | (o[3] ? 8'h60 : 8'h00)), 16'h0});
                    wr(8*c, 0, 32'h0);
                    if (o[0]) wr(8*c, 0, 32'h1);
                    if (o[1] || o[2]) eng(c, o[1], o[2], 0);
                    old = {1'b0, o[3], o[3], 2'b00, o[2], o[1], o[0]};
                    rd(8*c + 2, 0, q); chk("R7 setup state", q[23:16], old);
                    wr(8*c + 2, 0, {8'h0, 8'(w), 16'h0});
                    ex = (8'(w) & 8'h60) | (old & 8'h01) | (old & ~8'(w) & 8'h06);
                    rd(8*c + 2, 0, q); chk($sformatf("R4 st c=%0d old=%h w=%h", c, old, w), q[23:16], ex);
                    chk("R8 irq follows bit2", irq_o[c], ex[2]);
                end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule